// File: doc/BRIEF.md
# Rename History Buffer

This block keeps one hardware thread's log of register renames in an out-of-order core. Each time rename gives a destination register a new physical register, it writes an entry here. The entry holds the instruction's sequence number, the architectural register, the physical register just assigned, and the physical register it displaced. Entries are kept in age order in a circular store.

When a branch or fault squashes younger work, the block walks the log from the youngest entry backward. It undoes one mapping per cycle. For each undone entry it drives the displaced register to the map-table restore port and hands the discarded new register back to the free list. When instructions commit, the oldest entries whose sequence numbers are at or below the committed number drain from the other end. Up to a commit width of them drain per cycle, and their displaced registers go to the free-list release lanes.

Sequence numbers are compared modulo their width, so the log keeps working across a counter wrap.

Top module: `rename_history_buf`

## Requirements
- R1: After a synchronous active-high reset the block is empty, not full, not busy, and every valid output (`wr_err`, `restore_valid`, `rel_valid`) is low.
- R2: A write accepted while neither full nor busy stores one entry. `full` is high exactly when DEPTH entries are held, and `empty` is high exactly when none are held.
- R3: A write attempted while `full` or `busy` is high leaves the stored entries unchanged. `wr_err` is then high for one cycle, starting in the cycle after the attempt.
- R4: A commit pulse releases, starting in the next cycle, the oldest entries whose sequence number is at or below the committed number. At most CMT_W entries are released per cycle. Lane 0 carries the oldest released entry, the valid lanes always form a contiguous run starting at lane 0, and each lane's physical register is the entry's displaced register. Entries left over continue to drain on later cycles.
- R5: A squash pulse raises `busy` in the next cycle. From the cycle after that, one entry younger than the squash number is undone per cycle, youngest first. Each undone entry gives `restore_valid`, `restore_arch` (its architectural register), `restore_phys` (its displaced register) and `reclaim_phys` (its new register).
- R6: Rollback stops at the first entry that is not younger than the squash number. That entry and all older ones stay stored, and `busy` falls one cycle after the last restore.
- R7: "Younger" and "at or below" are judged by the sign bit of the SEQ_W-bit difference, so they hold across a wrap of the sequence counter.
- R8: No release happens in a cycle that follows a busy cycle. A commit pulse that arrives during rollback is remembered and drains once rollback ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Rename write request |
| wr_seq | input | SEQ_W | Sequence number of the renaming instruction |
| wr_arch | input | AREG_W | Architectural destination register |
| wr_new | input | PREG_W | Newly assigned physical register |
| wr_prev | input | PREG_W | Physical register displaced by the rename |
| cmt_valid | input | 1 | Commit pulse |
| cmt_seq | input | SEQ_W | Youngest committed sequence number |
| sq_valid | input | 1 | Squash pulse |
| sq_seq | input | SEQ_W | Squashing sequence number; younger entries are undone |
| full | output | 1 | No free entry |
| empty | output | 1 | No entry stored |
| busy | output | 1 | Rollback in progress; writes are refused |
| wr_err | output | 1 | Previous-cycle write was refused |
| restore_valid | output | 1 | Restore/reclaim outputs are valid |
| restore_arch | output | AREG_W | Map-table entry to restore |
| restore_phys | output | PREG_W | Physical register to write back into the map table |
| reclaim_phys | output | PREG_W | Undone new register returned to the free list |
| rel_valid | output | CMT_W | Per-lane release valid |
| rel_phys | output | CMT_W*PREG_W | Displaced registers freed at commit, lane i at bits [i*PREG_W +: PREG_W] |

## Verification
A head or tail pointer that is off by one shows up at the ports on the first drain or rollback after it. The released or restored physical register then belongs to the neighbouring entry, which is visible one cycle after the commit or two cycles after the squash. A wrong occupancy count shows as `full` or `empty` at the wrong time, or as a drain that stops early or runs past the last entry. A wrong age comparison shows as a rollback that undoes an old entry or keeps a young one, and the bench checks it across a sequence wrap. Refused writes are shown to leave no trace: after the log is drained, `empty` rises exactly when the accepted entries are gone.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  typedef enum logic {RB_IDLE, RB_WALK} rb_state_e;
endpackage

// File: rtl/rhb_ring.sv
// Circular entry store: one write port, NRD indexed read ports.
module rhb_ring #(
  parameter int DEPTH = 16,
  parameter int EW    = 8,
  parameter int NRD   = 1,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [PTR_W-1:0]     wr_idx,
  input  logic [EW-1:0]        wr_data,
  input  logic [NRD*PTR_W-1:0] rd_idx,
  output logic [NRD*EW-1:0]    rd_data
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  for (genvar i = 0; i < NRD; i++) begin : g_rd
    assign rd_data[i*EW +: EW] = mem[rd_idx[i*PTR_W +: PTR_W]];
  end
endmodule

// File: rtl/rhb_drain.sv
// Picks the contiguous run of oldest entries that the commit horizon covers.
module rhb_drain #(
  parameter int SEQ_W = 16,
  parameter int CMT_W = 4,
  parameter int CNT_W = 5,
  localparam int NT_W = $clog2(CMT_W+1)
) (
  input  logic                   en,
  input  logic [CNT_W-1:0]       count,
  input  logic [SEQ_W-1:0]       horizon,
  input  logic [CMT_W*SEQ_W-1:0] old_seq,
  output logic [CMT_W-1:0]       take,
  output logic [NT_W-1:0]        n_take
);
  function automatic logic seq_after(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return !d[SEQ_W-1] && (d != '0);
  endfunction

  logic [CMT_W-1:0] ok;
  for (genvar i = 0; i < CMT_W; i++) begin : g_lane
    logic here;
    assign here = en && (CNT_W'(i) < count) &&
                  !seq_after(old_seq[i*SEQ_W +: SEQ_W], horizon);
    if (i == 0) begin : g_first
      assign ok[i] = here;
    end else begin : g_rest
      assign ok[i] = here && ok[i-1];
    end
  end

  assign take = ok;

  always_comb begin
    n_take = '0;
    for (int i = 0; i < CMT_W; i++) n_take = n_take + NT_W'(ok[i]);
  end
endmodule

// File: rtl/rhb_rollback.sv
// Squash walker: pops the youngest entry each cycle while it is younger than the squash point.
module rhb_rollback #(
  parameter int SEQ_W = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic [SEQ_W-1:0] young_seq,
  input  logic [CNT_W-1:0] count,
  output logic             pop,
  output logic             busy
);
  import rhb_pkg::*;

  rb_state_e        state_q;
  logic [SEQ_W-1:0] sq_q;
  logic [SEQ_W-1:0] diff;

  assign diff = young_seq - sq_q;
  assign pop  = (state_q == RB_WALK) && (count != '0) &&
                !diff[SEQ_W-1] && (diff != '0);
  assign busy = (state_q == RB_WALK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RB_IDLE;
      sq_q    <= '0;
    end else if (sq_valid) begin
      state_q <= RB_WALK;
      sq_q    <= sq_seq;
    end else if (state_q == RB_WALK && !pop) begin
      state_q <= RB_IDLE;
    end
  end
endmodule

// File: rtl/rename_history_buf.sv
module rename_history_buf #(
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 7,
  parameter int DEPTH  = 16,
  parameter int CMT_W  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH+1),
  localparam int NT_W  = $clog2(CMT_W+1),
  localparam int SPW   = SEQ_W + PREG_W,
  localparam int ANW   = AREG_W + PREG_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_valid,
  input  logic [SEQ_W-1:0]        wr_seq,
  input  logic [AREG_W-1:0]       wr_arch,
  input  logic [PREG_W-1:0]       wr_new,
  input  logic [PREG_W-1:0]       wr_prev,
  input  logic                    cmt_valid,
  input  logic [SEQ_W-1:0]        cmt_seq,
  input  logic                    sq_valid,
  input  logic [SEQ_W-1:0]        sq_seq,
  output logic                    full,
  output logic                    empty,
  output logic                    busy,
  output logic                    wr_err,
  output logic                    restore_valid,
  output logic [AREG_W-1:0]       restore_arch,
  output logic [PREG_W-1:0]       restore_phys,
  output logic [PREG_W-1:0]       reclaim_phys,
  output logic [CMT_W-1:0]        rel_valid,
  output logic [CMT_W*PREG_W-1:0] rel_phys
);
  logic [PTR_W-1:0] head_q, tail_q, young_idx;
  logic [CNT_W-1:0] count_q;
  logic [SEQ_W-1:0] hz_q, hz_eff;
  logic             hz_valid_q;
  logic             wr_ok, pop;

  assign full      = (count_q == CNT_W'(DEPTH));
  assign empty     = (count_q == '0);
  assign wr_ok     = wr_valid && !full && !busy;
  assign young_idx = tail_q - PTR_W'(1);
  assign hz_eff    = cmt_valid ? cmt_seq : hz_q;

  // Store A: sequence number + displaced register (read by drain lanes and walker)
  logic [(CMT_W+1)*PTR_W-1:0] sp_rd_idx;
  logic [(CMT_W+1)*SPW-1:0]   sp_rd_data;
  for (genvar i = 0; i < CMT_W; i++) begin : g_idx
    assign sp_rd_idx[i*PTR_W +: PTR_W] = head_q + PTR_W'(i);
  end
  assign sp_rd_idx[CMT_W*PTR_W +: PTR_W] = young_idx;

  rhb_ring #(.DEPTH(DEPTH), .EW(SPW), .NRD(CMT_W+1)) u_sp (
    .clk    (clk),
    .wr_en  (wr_ok),
    .wr_idx (tail_q),
    .wr_data({wr_seq, wr_prev}),
    .rd_idx (sp_rd_idx),
    .rd_data(sp_rd_data)
  );

  // Store B: architectural register + new register (read only by walker)
  logic [ANW-1:0] an_rd_data;
  rhb_ring #(.DEPTH(DEPTH), .EW(ANW), .NRD(1)) u_an (
    .clk    (clk),
    .wr_en  (wr_ok),
    .wr_idx (tail_q),
    .wr_data({wr_arch, wr_new}),
    .rd_idx (young_idx),
    .rd_data(an_rd_data)
  );

  logic [CMT_W*SEQ_W-1:0]  old_seq;
  logic [CMT_W*PREG_W-1:0] old_prev;
  for (genvar i = 0; i < CMT_W; i++) begin : g_split
    assign old_seq[i*SEQ_W +: SEQ_W]    = sp_rd_data[i*SPW + PREG_W +: SEQ_W];
    assign old_prev[i*PREG_W +: PREG_W] = sp_rd_data[i*SPW +: PREG_W];
  end

  logic [SEQ_W-1:0]  young_seq;
  logic [PREG_W-1:0] young_prev;
  assign young_seq  = sp_rd_data[CMT_W*SPW + PREG_W +: SEQ_W];
  assign young_prev = sp_rd_data[CMT_W*SPW +: PREG_W];

  logic [CMT_W-1:0] take;
  logic [NT_W-1:0]  n_take;
  rhb_drain #(.SEQ_W(SEQ_W), .CMT_W(CMT_W), .CNT_W(CNT_W)) u_drain (
    .en     (!busy && (cmt_valid || hz_valid_q)),
    .count  (count_q),
    .horizon(hz_eff),
    .old_seq(old_seq),
    .take   (take),
    .n_take (n_take)
  );

  rhb_rollback #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_walk (
    .clk      (clk),
    .rst      (rst),
    .sq_valid (sq_valid),
    .sq_seq   (sq_seq),
    .young_seq(young_seq),
    .count    (count_q),
    .pop      (pop),
    .busy     (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q        <= '0;
      tail_q        <= '0;
      count_q       <= '0;
      hz_q          <= '0;
      hz_valid_q    <= 1'b0;
      wr_err        <= 1'b0;
      restore_valid <= 1'b0;
      restore_arch  <= '0;
      restore_phys  <= '0;
      reclaim_phys  <= '0;
      rel_valid     <= '0;
      rel_phys      <= '0;
    end else begin
      head_q  <= head_q + PTR_W'(n_take);
      tail_q  <= tail_q + PTR_W'(wr_ok) - PTR_W'(pop);
      count_q <= count_q + CNT_W'(wr_ok) - CNT_W'(n_take) - CNT_W'(pop);
      if (cmt_valid) begin
        hz_q       <= cmt_seq;
        hz_valid_q <= 1'b1;
      end
      wr_err        <= wr_valid && !wr_ok;
      restore_valid <= pop;
      if (pop) begin
        restore_arch <= an_rd_data[PREG_W +: AREG_W];
        restore_phys <= young_prev;
        reclaim_phys <= an_rd_data[PREG_W-1:0];
      end
      rel_valid <= take;
      rel_phys  <= old_prev;
    end
  end
endmodule

// File: rtl/rhb_checker.sv
module rhb_checker #(
  parameter int CMT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic             full,
  input logic             empty,
  input logic             busy,
  input logic             wr_err,
  input logic             restore_valid,
  input logic [CMT_W-1:0] rel_valid
);
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(full && empty)); // R2

  AST_WR_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(wr_valid && (full || busy))); // R3

  AST_REL_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
    (rel_valid & (rel_valid + CMT_W'(1))) == '0); // R4

  AST_RESTORE_IN_WALK: assert property (@(posedge clk) disable iff (rst)
    restore_valid |-> $past(busy)); // R5

  AST_NO_REL_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> (rel_valid == '0)); // R8

  AST_RESTORE_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    restore_valid |-> !$past(empty)); // R6
endmodule

bind rename_history_buf rhb_checker #(.CMT_W(CMT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_valid     (wr_valid),
  .full         (full),
  .empty        (empty),
  .busy         (busy),
  .wr_err       (wr_err),
  .restore_valid(restore_valid),
  .rel_valid    (rel_valid)
);

// File: tb/rename_history_buf_tb.sv
`timescale 1ns/1ps
module rename_history_buf_tb;
  localparam int SEQ_W = 16, AREG_W = 5, PREG_W = 7, DEPTH = 8, CMT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0, cmt_valid = 1'b0, sq_valid = 1'b0;
  logic [SEQ_W-1:0] wr_seq = '0, cmt_seq = '0, sq_seq = '0;
  logic [AREG_W-1:0] wr_arch = '0;
  logic [PREG_W-1:0] wr_new = '0, wr_prev = '0;
  logic full, empty, busy, wr_err, restore_valid;
  logic [AREG_W-1:0] restore_arch;
  logic [PREG_W-1:0] restore_phys, reclaim_phys;
  logic [CMT_W-1:0] rel_valid;
  logic [CMT_W*PREG_W-1:0] rel_phys;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  rename_history_buf #(.SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W),
                       .DEPTH(DEPTH), .CMT_W(CMT_W)) u_dut (.*);

  typedef struct packed {
    logic [15:0] seq;
    logic [4:0]  arch;
    logic [6:0]  np;
    logic [6:0]  pp;
    logic        exp_full;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{16'd10, 5'd1, 7'd32, 7'd16, 1'b0},
    '{16'd11, 5'd2, 7'd33, 7'd17, 1'b0},
    '{16'd12, 5'd3, 7'd34, 7'd18, 1'b0},
    '{16'd13, 5'd4, 7'd35, 7'd19, 1'b0},
    '{16'd14, 5'd5, 7'd36, 7'd20, 1'b0},
    '{16'd15, 5'd6, 7'd37, 7'd21, 1'b0},
    '{16'd16, 5'd7, 7'd38, 7'd22, 1'b0},
    '{16'd17, 5'd8, 7'd39, 7'd23, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write(input logic [15:0] s, input logic [4:0] a,
                       input logic [6:0] n, input logic [6:0] p);
    wr_valid = 1'b1; wr_seq = s; wr_arch = a; wr_new = n; wr_prev = p;
    step();
    wr_valid = 1'b0;
  endtask

  function automatic logic [6:0] lane(input int i);
    return rel_phys[i*PREG_W +: PREG_W];
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 empty", 32'(empty), 1);
    chk("R1 full", 32'(full), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 valids", {29'd0, wr_err, restore_valid, |rel_valid}, 0);

    // R2 fill from the vector table
    for (int i = 0; i < 8; i++) begin
      write(VEC[i].seq, VEC[i].arch, VEC[i].np, VEC[i].pp);
      chk("R2 full flag", 32'(full), 32'(VEC[i].exp_full));
      chk("R2 not empty", 32'(empty), 0);
    end

    // R3 write while full
    write(16'd99, 5'd9, 7'd99, 7'd98);
    chk("R3 wr_err on full", 32'(wr_err), 1);
    step();
    chk("R3 wr_err pulse", 32'(wr_err), 0);

    // R4 commit 11 releases two oldest
    cmt_valid = 1'b1; cmt_seq = 16'd11;
    step();
    cmt_valid = 1'b0;
    chk("R4 mask a", 32'(rel_valid), 32'h3);
    chk("R4 lane0 a", 32'(lane(0)), 16);
    chk("R4 lane1 a", 32'(lane(1)), 17);
    chk("R2 full clears", 32'(full), 0);

    // R4 commit 17: width limit, then remainder
    cmt_valid = 1'b1; cmt_seq = 16'd17;
    step();
    cmt_valid = 1'b0;
    chk("R4 mask b", 32'(rel_valid), 32'hF);
    chk("R4 lane0 b", 32'(lane(0)), 18);
    chk("R4 lane3 b", 32'(lane(3)), 21);
    step();
    chk("R4 mask c", 32'(rel_valid), 32'h3);
    chk("R4 lane0 c", 32'(lane(0)), 22);
    chk("R4 lane1 c", 32'(lane(1)), 23);
    step();
    chk("R4 mask idle", 32'(rel_valid), 0);
    chk("R3 refused entry absent", 32'(empty), 1);

    // R5/R6 squash rollback
    for (int k = 0; k < 5; k++)
      write(16'(20 + k), 5'(1 + k), 7'(40 + k), 7'(60 + k));
    sq_valid = 1'b1; sq_seq = 16'd21;
    step();
    sq_valid = 1'b0;
    chk("R5 busy rises", 32'(busy), 1);
    chk("R5 no restore yet", 32'(restore_valid), 0);
    wr_valid = 1'b1; wr_seq = 16'd30; wr_arch = 5'd9; wr_new = 7'd90; wr_prev = 7'd91;
    step();
    wr_valid = 1'b0;
    chk("R3 wr_err on busy", 32'(wr_err), 1);
    chk("R5 restore 1 valid", 32'(restore_valid), 1);
    chk("R5 restore 1", {restore_arch, restore_phys, reclaim_phys}, {5'd5, 7'd64, 7'd44});
    step();
    chk("R5 restore 2", {restore_valid, restore_arch, restore_phys, reclaim_phys},
        {1'b1, 5'd4, 7'd63, 7'd43});
    step();
    chk("R5 restore 3", {restore_valid, restore_arch, restore_phys, reclaim_phys},
        {1'b1, 5'd3, 7'd62, 7'd42});
    chk("R6 busy during walk", 32'(busy), 1);
    chk("R8 no release in walk", 32'(rel_valid), 0);
    step();
    chk("R6 walk ends", 32'(busy), 0);
    chk("R6 no extra restore", 32'(restore_valid), 0);
    cmt_valid = 1'b1; cmt_seq = 16'd25;
    step();
    cmt_valid = 1'b0;
    chk("R6 kept entries", 32'(rel_valid), 32'h3);
    chk("R6 kept lane0", 32'(lane(0)), 60);
    chk("R6 kept lane1", 32'(lane(1)), 61);
    step();
    chk("R6 nothing else kept", 32'(empty), 1);

    // R7 wrap-safe ordering
    do_reset();
    chk("R1 empty after reset", 32'(empty), 1);
    write(16'hFFFE, 5'd1, 7'd10, 7'd20);
    write(16'hFFFF, 5'd2, 7'd11, 7'd21);
    write(16'h0000, 5'd3, 7'd12, 7'd22);
    write(16'h0001, 5'd4, 7'd13, 7'd23);
    sq_valid = 1'b1; sq_seq = 16'hFFFF;
    step();
    sq_valid = 1'b0;
    step();
    chk("R7 undo seq 1", {restore_valid, restore_arch, restore_phys}, {1'b1, 5'd4, 7'd23});
    step();
    chk("R7 undo seq 0", {restore_valid, restore_arch, restore_phys}, {1'b1, 5'd3, 7'd22});
    step();
    chk("R7 stop at FFFF", {busy, restore_valid}, 0);
    cmt_valid = 1'b1; cmt_seq = 16'hFFFF;
    step();
    cmt_valid = 1'b0;
    chk("R7 commit across wrap", 32'(rel_valid), 32'h3);
    chk("R7 lane0", 32'(lane(0)), 20);
    chk("R7 lane1", 32'(lane(1)), 21);
    step();
    chk("R7 drained", 32'(empty), 1);

    // R8 commit during rollback is deferred
    write(16'd5, 5'd1, 7'd1, 7'd2);
    write(16'd6, 5'd2, 7'd3, 7'd4);
    sq_valid = 1'b1; sq_seq = 16'd5;
    step();
    sq_valid = 1'b0;
    cmt_valid = 1'b1; cmt_seq = 16'd5;
    step();
    cmt_valid = 1'b0;
    chk("R8 held during walk", 32'(rel_valid), 0);
    step();
    step();
    chk("R8 drains after walk", 32'(rel_valid), 32'h1);
    chk("R8 lane0", 32'(lane(0)), 2);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule